// File: doc/BRIEF.md
# GPIO Interrupt Front End with Glitch Filter

This block sits between a bank of GPIO-derived interrupt inputs and a parent interrupt controller. Each of up to 24 lines has three control bits: an enable, a both-edge mode select and a filter enable. One filter period is shared by all lines. The filter is per line. It only accepts a new input level once that level has been steady for the programmed number of clock cycles. The filter only affects the interrupt outputs and leaves the GPIO data path alone.

A line with both-edge mode and its filter enabled turns every filtered transition, in either direction, into a one-cycle low pulse on an output that otherwise idles high. The parent controller therefore only needs falling-edge detection on that line. Other enabled lines pass their input to the output, filtered or not. Software programs the block through a small write port and a combinational read port. Four word registers sit in a fixed address window.

Top module: `gpio_irq_front`

## Requirements
- R1: After reset every control register reads zero, the shared period reads zero and every irq_out bit is 0.
- R2: The registers sit at byte offsets 0x90 (line enable), 0x94 (both-edge mode, 1 = both edges), 0x98 (filter enable) and 0x9C (shared period, low 8 bits). Bit n of each per-line register belongs to line n. Bits above the implemented width read 0. Any other address reads 0, and writes to it change nothing.
- R3: A disabled line drives irq_out high if both its mode bit and its filter-enable bit are set. Otherwise a disabled line drives irq_out low. The level does not depend on the line input.
- R4: An enabled line whose filter-enable bit is 0 drives irq_out equal to line_in in the same cycle, with no clock in between. Its mode bit is ignored.
- R5: For an enabled line with filter enabled and mode 0, irq_out is the filtered level. The filtered level takes a new value at the P-th consecutive rising clock edge at which line_in differs from it. P is the period register, and a value of 0 acts as 1.
- R6: A change of line_in that lasts fewer than P consecutive sampling edges leaves the filtered level, and so irq_out, unchanged.
- R7: For an enabled line with both mode and filter enabled, irq_out idles at 1. After each clock edge that changes the filtered level, in either direction, irq_out goes to 0 for exactly one cycle.
- R8: A single period write applies to every line at once. Periods of 1 and 0 both let the filtered level follow at the first differing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchroniser |
| reg_we | input | 1 | Register write strobe, sampled on the rising edge |
| reg_addr | input | 8 | Register byte address for both reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| line_in | input | 24 | Raw interrupt inputs, one per line |
| irq_out | output | 24 | Interrupt outputs to the parent controller |

## Verification
Each result has its own due time. A register write shows in reg_rdata after the edge that takes it. An unfiltered enabled line follows line_in within the same cycle. A filtered line changes after the P-th differing edge. The both-edge low pulse appears right after that edge and clears on the next one. Inputs are changed 2 ns after a rising edge and results are sampled 1 ns later or at the falling edge. Directed checks count edges from the change that caused them, so each check lands in the cycle where its result is due. A cycle-by-cycle reference model in the bench steps on every rising edge and is compared with both outputs at every falling edge. This covers random traffic that mixes modes, periods and register rewrites.

// File: rtl/gpirq_pkg.sv
package gpirq_pkg;

  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_ENABLE = 8'h90;
  localparam logic [ADDR_W-1:0] OFS_MODE   = 8'h94;
  localparam logic [ADDR_W-1:0] OFS_FLTEN  = 8'h98;
  localparam logic [ADDR_W-1:0] OFS_PERIOD = 8'h9C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ENABLE,
    SEL_MODE,
    SEL_FLTEN,
    SEL_PERIOD
  } reg_sel_e;

  typedef enum logic [1:0] {
    KIND_OFF,
    KIND_PASS,
    KIND_FILT,
    KIND_BOTH
  } line_kind_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    case (a)
      OFS_ENABLE: s = SEL_ENABLE;
      OFS_MODE:   s = SEL_MODE;
      OFS_FLTEN:  s = SEL_FLTEN;
      OFS_PERIOD: s = SEL_PERIOD;
      default:    s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/gpirq_rst_sync.sv
module gpirq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/gpirq_regs.sv
module gpirq_regs
  import gpirq_pkg::*;
#(
  parameter int N_LINES = 24,
  parameter int PER_W   = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [N_LINES-1:0] en_o,
  output logic [N_LINES-1:0] mode_o,
  output logic [N_LINES-1:0] fen_o,
  output logic [PER_W-1:0]   per_o,
  output logic [DATA_W-1:0]  rdata
);

  localparam int HI_W = (N_LINES > PER_W) ? N_LINES : PER_W;

  reg_sel_e           sel;
  logic [N_LINES-1:0] en_q, mode_q, fen_q;
  logic [N_LINES-1:0] line_d;
  logic [PER_W-1:0]   per_q, per_d;
  logic               en_ce, mode_ce, fen_ce, per_ce;
  logic               unused_wdata;

  assign sel = decode_addr(addr);

  // next-state and clock enables
  always_comb begin
    line_d  = wdata[N_LINES-1:0];
    per_d   = wdata[PER_W-1:0];
    en_ce   = wr_en && (sel == SEL_ENABLE);
    mode_ce = wr_en && (sel == SEL_MODE);
    fen_ce  = wr_en && (sel == SEL_FLTEN);
    per_ce  = wr_en && (sel == SEL_PERIOD);
  end

  assign unused_wdata = ^wdata[DATA_W-1:HI_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= '0;
      fen_q  <= '0;
      per_q  <= '0;
    end else begin
      if (en_ce)   en_q   <= line_d;
      if (mode_ce) mode_q <= line_d;
      if (fen_ce)  fen_q  <= line_d;
      if (per_ce)  per_q  <= per_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_ENABLE: rdata[N_LINES-1:0] = en_q;
      SEL_MODE:   rdata[N_LINES-1:0] = mode_q;
      SEL_FLTEN:  rdata[N_LINES-1:0] = fen_q;
      SEL_PERIOD: rdata[PER_W-1:0]   = per_q;
      default:    rdata = '0;
    endcase
  end

  assign en_o   = en_q;
  assign mode_o = mode_q;
  assign fen_o  = fen_q;
  assign per_o  = per_q;

endmodule

// File: rtl/gpirq_filter.sv
module gpirq_filter #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_i,
  input  logic [PER_W-1:0] period_i,
  output logic             filt_o
);

  logic [PER_W-1:0] run_q, run_d;
  logic             filt_q, filt_d;
  logic [PER_W:0]   need, seen;
  logic             differs, ce;

  always_comb begin
    need    = (period_i == '0) ? {{PER_W{1'b0}}, 1'b1} : {1'b0, period_i};
    seen    = {1'b0, run_q} + {{PER_W{1'b0}}, 1'b1};
    differs = (raw_i != filt_q);
    filt_d  = filt_q;
    run_d   = '0;
    if (differs) begin
      if (seen >= need) begin
        filt_d = raw_i;
        run_d  = '0;
      end else begin
        run_d  = seen[PER_W-1:0];
      end
    end
    ce = differs || (run_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      filt_q <= 1'b0;
    end else if (ce) begin
      run_q  <= run_d;
      filt_q <= filt_d;
    end
  end

  assign filt_o = filt_q;

endmodule

// File: rtl/gpirq_shaper.sv
module gpirq_shaper
  import gpirq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic mode_i,
  input  logic fen_i,
  input  logic raw_i,
  input  logic filt_i,
  output logic irq_o
);

  logic       prev_q;
  logic       both;
  line_kind_e kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= filt_i;
    end
  end

  always_comb begin
    both = mode_i && fen_i;
    if (!en_i)      kind = KIND_OFF;
    else if (both)  kind = KIND_BOTH;
    else if (fen_i) kind = KIND_FILT;
    else            kind = KIND_PASS;

    case (kind)
      KIND_OFF:  irq_o = both;
      KIND_BOTH: irq_o = ~(filt_i ^ prev_q);
      KIND_FILT: irq_o = filt_i;
      default:   irq_o = raw_i;
    endcase
  end

endmodule

// File: rtl/gpio_irq_front.sv
module gpio_irq_front
  import gpirq_pkg::*;
#(
  parameter int N_LINES     = 24,
  parameter int PER_W       = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [N_LINES-1:0] line_in,
  output logic [N_LINES-1:0] irq_out
);

  logic               rst_sync_n;
  logic [N_LINES-1:0] en_q, mode_q, fen_q, filt_q;
  logic [PER_W-1:0]   per_q;

  gpirq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpirq_regs #(.N_LINES(N_LINES), .PER_W(PER_W), .DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (reg_we),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .en_o   (en_q),
    .mode_o (mode_q),
    .fen_o  (fen_q),
    .per_o  (per_q),
    .rdata  (reg_rdata)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    gpirq_filter #(.PER_W(PER_W)) u_filt (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .raw_i    (line_in[i]),
      .period_i (per_q),
      .filt_o   (filt_q[i])
    );

    gpirq_shaper u_shape (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .en_i   (en_q[i]),
      .mode_i (mode_q[i]),
      .fen_i  (fen_q[i]),
      .raw_i  (line_in[i]),
      .filt_i (filt_q[i]),
      .irq_o  (irq_out[i])
    );
  end

endmodule

// File: rtl/gpirq_checker.sv
module gpirq_checker
  import gpirq_pkg::*;
#(
  parameter int N_LINES = 24,
  parameter int PER_W   = 8,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic [N_LINES-1:0] line_in,
  input logic [N_LINES-1:0] irq_out,
  input logic [N_LINES-1:0] en_q,
  input logic [N_LINES-1:0] mode_q,
  input logic [N_LINES-1:0] fen_q,
  input logic [PER_W-1:0]   per_q,
  input logic [N_LINES-1:0] filt_q
);

  a_r2_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == OFS_ENABLE || reg_addr == OFS_MODE || reg_addr == OFS_FLTEN)
      |-> ((reg_rdata >> N_LINES) == '0));

  a_r2_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (decode_addr(reg_addr) == SEL_NONE) |-> (reg_rdata == '0));

  for (genvar i = 0; i < N_LINES; i++) begin : g_chk
    a_r3_off_level: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q[i]) |-> (irq_out[i] == (mode_q[i] && fen_q[i])));

    a_r4_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[i] && !fen_q[i]) |-> (irq_out[i] == line_in[i]));

    a_r5_filter_takes_raw: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_q[i] != $past(filt_q[i])) |-> ($past(line_in[i]) == filt_q[i]));

    a_r6_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(per_q) >= 2 && filt_q[i] != $past(filt_q[i]))
        |-> ($past(line_in[i], 2) == filt_q[i]));

    a_r7_single_low: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[i] && mode_q[i] && fen_q[i] && !irq_out[i])
        |=> (!(en_q[i] && mode_q[i] && fen_q[i]) || irq_out[i]
             || (filt_q[i] != $past(filt_q[i]))));
  end

endmodule

bind gpio_irq_front gpirq_checker #(
  .N_LINES (N_LINES),
  .PER_W   (PER_W),
  .DATA_W  (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .line_in   (line_in),
  .irq_out   (irq_out),
  .en_q      (en_q),
  .mode_q    (mode_q),
  .fen_q     (fen_q),
  .per_q     (per_q),
  .filt_q    (filt_q)
);

// File: tb/tb_gpio_irq_front.sv
`timescale 1ns/1ps
module tb_gpio_irq_front;

  localparam int N  = 24;
  localparam int PW = 8;
  localparam int DW = 32;
  localparam logic [N-1:0] ALL = {N{1'b1}};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_we;
  logic [7:0]    reg_addr;
  logic [DW-1:0] reg_wdata;
  logic [DW-1:0] reg_rdata;
  logic [N-1:0]  line_in;
  logic [N-1:0]  irq_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit cmp_on   = 0;
  bit done     = 0;

  // reference model state
  logic [N-1:0] m_en, m_mode, m_fen, m_filt, m_prev;
  int           m_run [N];
  int           m_per;

  always #10 clk = ~clk;

  gpio_irq_front dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .line_in   (line_in),
    .irq_out   (irq_out)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = '0; m_mode = '0; m_fen = '0; m_filt = '0; m_prev = '0; m_per = 0;
      for (int i = 0; i < N; i++) m_run[i] = 0;
    end else begin
      int need;
      need   = (m_per == 0) ? 1 : m_per;
      m_prev = m_filt;
      for (int i = 0; i < N; i++) begin
        if (line_in[i] != m_filt[i]) begin
          m_run[i] = m_run[i] + 1;
          if (m_run[i] >= need) begin
            m_filt[i] = line_in[i];
            m_run[i]  = 0;
          end
        end else begin
          m_run[i] = 0;
        end
      end
      if (reg_we) begin
        case (reg_addr)
          8'h90: m_en   = reg_wdata[N-1:0];
          8'h94: m_mode = reg_wdata[N-1:0];
          8'h98: m_fen  = reg_wdata[N-1:0];
          8'h9C: m_per  = int'(reg_wdata[PW-1:0]);
          default: ;
        endcase
      end
    end
  end

  function automatic logic model_irq(int i);
    logic both;
    both = m_mode[i] && m_fen[i];
    if (!m_en[i])  return both;
    if (both)      return ~(m_filt[i] ^ m_prev[i]);
    if (m_fen[i])  return m_filt[i];
    return line_in[i];
  endfunction

  function automatic string line_tag(int i);
    if (!m_en[i])                return "R3";
    if (m_mode[i] && m_fen[i])   return "R7";
    if (m_fen[i])                return "R5";
    return "R4";
  endfunction

  function automatic logic [DW-1:0] model_rd(logic [7:0] a);
    logic [DW-1:0] v;
    v = '0;
    case (a)
      8'h90: v[N-1:0]  = m_en;
      8'h94: v[N-1:0]  = m_mode;
      8'h98: v[N-1:0]  = m_fen;
      8'h9C: v[PW-1:0] = m_per[PW-1:0];
      default: v = '0;
    endcase
    return v;
  endfunction

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (cmp_on) begin
      logic [N-1:0] exp_irq;
      logic [DW-1:0] exp_rd;
      for (int i = 0; i < N; i++) exp_irq[i] = model_irq(i);
      n_checks++;
      if (irq_out !== exp_irq) begin
        int bad;
        bad = 0;
        for (int i = N - 1; i >= 0; i--) if (irq_out[i] !== exp_irq[i]) bad = i;
        n_fail++;
        $display("FAIL %s model line %0d: irq_out=%h expected %h", line_tag(bad), bad, irq_out, exp_irq);
      end
      exp_rd = model_rd(reg_addr);
      n_checks++;
      if (reg_rdata !== exp_rd) begin
        n_fail++;
        $display("FAIL R2 model readback addr %h: rdata=%h expected %h", reg_addr, reg_rdata, exp_rd);
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      summary();
      $finish;
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(logic [7:0] a, logic [DW-1:0] d);
    step();
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(logic [7:0] a, logic [DW-1:0] exp, string tag);
    reg_addr = a;
    #1;
    n_checks++;
    if (reg_rdata !== exp) begin
      n_fail++;
      $display("FAIL %s read %h: got %h expected %h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic irq_chk(logic [N-1:0] mask, logic [N-1:0] exp, string tag);
    #1;
    n_checks++;
    if ((irq_out & mask) !== (exp & mask)) begin
      n_fail++;
      $display("FAIL %s irq_out&%h: got %h expected %h", tag, mask, irq_out & mask, exp & mask);
    end
  endtask

  initial begin
    int lows;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 8'h90; reg_wdata = '0; line_in = '0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    step(4);
    cmp_on = 1;

    // R1: reset state
    rd_chk(8'h90, '0, "R1");
    rd_chk(8'h94, '0, "R1");
    rd_chk(8'h98, '0, "R1");
    rd_chk(8'h9C, '0, "R1");
    irq_chk(ALL, '0, "R1");

    // R2: map, width, unmapped address
    wr(8'h90, 32'hFFFF_FFFF);
    rd_chk(8'h90, 32'h00FF_FFFF, "R2");
    wr(8'h9C, 32'h0000_01FF);
    rd_chk(8'h9C, 32'h0000_00FF, "R2");
    wr(8'hA0, 32'h1234_5678);
    rd_chk(8'hA0, '0, "R2");
    rd_chk(8'h90, 32'h00FF_FFFF, "R2");
    rd_chk(8'h94, '0, "R2");
    rd_chk(8'h98, '0, "R2");

    // R4: unfiltered pass-through, mode ignored
    wr(8'h94, 32'h0000_00FF);
    line_in = 24'hA5A5A5;
    irq_chk(ALL, 24'hA5A5A5, "R4");
    line_in = 24'h3C3C3C;
    irq_chk(ALL, 24'h3C3C3C, "R4");

    // R3: disabled level
    wr(8'h90, 32'h0);
    wr(8'h94, 32'h00FF_FFFF);
    wr(8'h98, 32'h0000_F0F0);
    line_in = 24'h5A5A5A;
    irq_chk(ALL, 24'h00F0F0, "R3");
    line_in = 24'h000000;
    step(8);
    irq_chk(ALL, 24'h00F0F0, "R3");

    // R5: filtered level with period 4
    wr(8'h94, 32'h0);
    wr(8'h98, 32'h00FF_FFFF);
    wr(8'h9C, 32'd4);
    wr(8'h90, 32'h00FF_FFFF);
    step();
    line_in[0] = 1'b1;
    step(3);
    irq_chk(24'h1, 24'h0, "R5");
    step();
    irq_chk(24'h1, 24'h1, "R5");

    // R6: three-cycle glitch under period 4
    line_in[1] = 1'b1;
    step(3);
    line_in[1] = 1'b0;
    step(5);
    irq_chk(24'h2, 24'h0, "R6");

    // R8: shared period 1, 0 and 2
    wr(8'h9C, 32'd1);
    line_in[3:2] = 2'b11;
    step();
    irq_chk(24'hC, 24'hC, "R8");
    wr(8'h9C, 32'd0);
    line_in[3:2] = 2'b00;
    step();
    irq_chk(24'hC, 24'h0, "R8");
    wr(8'h9C, 32'd2);
    line_in[5:4] = 2'b11;
    step();
    irq_chk(24'h30, 24'h0, "R8");
    step();
    irq_chk(24'h30, 24'h30, "R8");

    // R7: both-edge pulses, period 1
    wr(8'h9C, 32'd1);
    wr(8'h94, 32'h0000_0100);
    step();
    irq_chk(24'h100, 24'h100, "R7");
    line_in[8] = 1'b1;
    lows = 0;
    for (int k = 0; k < 6; k++) begin
      step();
      #1 if (!irq_out[8]) lows++;
    end
    n_checks++;
    if (lows != 1) begin
      n_fail++;
      $display("FAIL R7 rising transition: low cycles=%0d expected 1", lows);
    end
    line_in[8] = 1'b0;
    lows = 0;
    for (int k = 0; k < 6; k++) begin
      step();
      #1 if (!irq_out[8]) lows++;
    end
    n_checks++;
    if (lows != 1) begin
      n_fail++;
      $display("FAIL R7 falling transition: low cycles=%0d expected 1", lows);
    end

    // random traffic across modes and periods, checked by the model
    wr(8'h98, {8'h0, 24'($urandom)});
    wr(8'h94, {8'h0, 24'($urandom)});
    wr(8'h9C, 32'd3);
    for (int k = 0; k < 600; k++) begin
      step();
      if (($urandom % 4) == 0) line_in = line_in ^ (24'($urandom) & 24'($urandom));
      if (k == 200) begin
        wr(8'h9C, 32'd0);
        wr(8'h90, {8'h0, 24'($urandom)});
      end
      if (k == 400) begin
        wr(8'h9C, 32'd5);
        wr(8'h98, 32'h00FF_FFFF);
      end
    end
    step(8);

    done = 1;
    cmp_on = 0;
    summary();
    $finish;
  end

endmodule